// File: doc/BRIEF.md
# Up/Down Auto-Reload Capture Timer

A parameterized timer/counter, 16 bits wide by default, paired with one register of the same width. That register holds the reload value or receives a captured count. The block has three operating styles.

- In capture style, the counter runs freely upward. A falling edge on the external control pin copies the count into the register.
- In up-counting reload style, an overflow restarts the count from the register. A falling edge on the pin can also force that restart.
- In up/down style, the level of the pin picks the direction. The counter wraps between the register value and all-ones in both directions.

A toggle output can flip on each overflow, which gives a square wave derived from the count rate.

The surrounding logic supplies a count enable and a one-cycle count tick. It also tells the block whether the tick comes from an internal prescaler or from an outside event. Software reaches the block through write strobes for the counter, the register, the configuration bits and the flag-clear bits. It reads the state back through plain outputs.

Top module: `updn_reload_timer`

## Requirements
- R1: After reset the counter, the reload/capture register, the configuration, both flags and the toggle output are all zero.
- R2: With configuration bit 0 (capture) and bit 2 (direction-enable) clear, each accepted tick (run and tick both high) adds one. A tick at all-ones loads the register value instead and sets the overflow flag.
- R3: In the mode of R2 with bit 1 (external-enable) set, a falling edge of the control pin loads the register value into the counter and sets the external flag. This happens on the third rising clock edge after the pin falls. With bit 1 clear, the edge has no effect.
- R4: With bit 2 set and bit 0 clear, a synchronized pin level of 1 counts up and 0 counts down. Counting up at all-ones loads the register value. Counting down while the count equals the register value loads all-ones. Both wraps set the overflow flag.
- R5: In the mode of R4, the external flag inverts on every wrap in either direction. A falling edge of the pin does not set it.
- R6: With bit 0 set, the counter wraps from all-ones to zero and sets the overflow flag. With bit 1 also set, a falling edge of the pin copies the count into the register and sets the external flag.
- R7: With bit 3 (output-enable) set and the tick source marked internal (tick_ext_src low), the toggle output inverts on each overflow. It holds when bit 3 is clear or when the ticks are marked external.
- R8: A flag falls only through its clear strobe: flag_clr bit 0 clears the overflow flag and bit 1 clears the external flag. A hardware event in the same cycle as a clear leaves the flag set.
- R9: A counter write takes effect on the next edge even when an overflow would have happened on that edge. The overflow flag and the toggle output then stay unchanged.
- R10: Without an accepted tick, and without a write or pin-driven reload, the count holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Count enable |
| tick | input | 1 | One-cycle count pulse |
| tick_ext_src | input | 1 | High when ticks come from an outside event |
| ctl_pin | input | 1 | External control pin, asynchronous |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | W | Counter write value |
| rld_we | input | 1 | Reload/capture register write strobe |
| rld_wdata | input | W | Register write value |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 4 | Bits: 3 output-enable, 2 direction-enable, 1 external-enable, 0 capture |
| flag_clr | input | 2 | Bit 0 clears the overflow flag, bit 1 clears the external flag |
| cnt_q | output | W | Counter value |
| rld_q | output | W | Reload/capture register value |
| cfg_q | output | 4 | Configuration readback |
| ovf_flag | output | 1 | Overflow/underflow flag |
| ext_flag | output | 1 | External-event flag, or wrap parity in up/down style |
| tgl_out | output | 1 | Overflow toggle output |

## Verification
The assertions take two things for granted. The tick arrives as a pulse already qualified by the surrounding prescaler. The control pin may change at any time, because it passes through the synchronizer before any check looks at it. The stimulus changes the pin only while ticks are held off. It then waits the three synchronizer edges before ticking again, so each direction change and each falling edge acts at a known cycle. Configuration changes are made with ticks stopped, which keeps every count sequence tied to a single style.

// File: rtl/urt_pkg.sv
package urt_pkg;
   typedef struct packed {
      logic out_en;   // bit 3
      logic dir_en;   // bit 2
      logic ext_en;   // bit 1
      logic capture;  // bit 0
   } urt_cfg_t;

   localparam int URT_CFG_W = $bits(urt_cfg_t);
endpackage

// File: rtl/urt_sync_edge.sv
module urt_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic level,
   output logic fall
);
   localparam int LAST = STAGES - 1;

   initial begin
      assert (STAGES >= 2) else $error("urt_sync_edge: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;
   logic              prev;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[0] <= 1'b1;
               else        chain[0] <= pin;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[i] <= 1'b1;
               else        chain[i] <= chain[i-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prev <= 1'b1;
      else        prev <= chain[LAST];

   assign level = chain[LAST];
   assign fall  = prev & ~chain[LAST];

   // R3: a detected fall always follows a high sample
   a_r3_fall_after_high: assert property (@(posedge clk) disable iff (!rst_n)
      fall |-> $past(level));
endmodule

// File: rtl/urt_count_core.sv
module urt_count_core
   import urt_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic         tick,
   input  urt_cfg_t     cfg,
   input  logic         dir_level,
   input  logic         fall,
   input  logic         cnt_we,
   input  logic [W-1:0] cnt_wdata,
   input  logic         rld_we,
   input  logic [W-1:0] rld_wdata,
   output logic [W-1:0] cnt_q,
   output logic [W-1:0] rld_q,
   output logic         ovf_evt,
   output logic         ext_evt,
   output logic         updn
);
   localparam logic [W-1:0] ALL1 = {W{1'b1}};
   localparam logic [W-1:0] ZERO = '0;
   localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

   initial begin
      assert (W >= 2) else $error("urt_count_core: W must be at least 2");
   end

   logic adv, up, at_max, at_rld, reload_hit, capture_hit;
   logic [W-1:0] cnt_d, rld_d, wrap_val;

   always_comb begin
      adv         = run & tick;
      updn        = cfg.dir_en & ~cfg.capture;
      up          = ~updn | dir_level;
      at_max      = (cnt_q == ALL1);
      at_rld      = (cnt_q == rld_q);
      reload_hit  = cfg.ext_en & fall & ~updn & ~cfg.capture;
      capture_hit = cfg.ext_en & fall & cfg.capture;
      ovf_evt     = adv & ~cnt_we & ~reload_hit & (up ? at_max : at_rld);
      ext_evt     = (reload_hit & ~cnt_we) | capture_hit;
      wrap_val    = cfg.capture ? ZERO : rld_q;

      cnt_d = cnt_q;
      if (cnt_we)          cnt_d = cnt_wdata;
      else if (reload_hit) cnt_d = rld_q;
      else if (adv) begin
         if (up) cnt_d = at_max ? wrap_val : cnt_q + ONE;
         else    cnt_d = at_rld ? ALL1 : cnt_q - ONE;
      end

      rld_d = rld_q;
      if (rld_we)           rld_d = rld_wdata;
      else if (capture_hit) rld_d = cnt_q;
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         cnt_q <= ZERO;
         rld_q <= ZERO;
      end else begin
         cnt_q <= cnt_d;
         rld_q <= rld_d;
      end

   // R2: up-count wrap restarts from the register
   a_r2_up_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !updn && !cfg.capture && !cnt_we && !reload_hit && at_max)
      |=> cnt_q == $past(rld_q));
   // R4: down-count at the register value lands on all-ones
   a_r4_down_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && updn && !dir_level && !cnt_we && at_rld) |=> cnt_q == ALL1);
   // R6: capture copies the count
   a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (capture_hit && !rld_we) |=> rld_q == $past(cnt_q));
   // R9: software write wins
   a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_we |=> cnt_q == $past(cnt_wdata));
   // R10: count holds without a tick
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_we && !adv && !reload_hit) |=> $stable(cnt_q));
endmodule

// File: rtl/urt_flag_out.sv
module urt_flag_out #(
   parameter bit HAS_TOGGLE = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ovf_evt,
   input  logic       ext_evt,
   input  logic       updn,
   input  logic       out_en,
   input  logic       tick_ext_src,
   input  logic [1:0] flag_clr,
   output logic       ovf_flag,
   output logic       ext_flag,
   output logic       tgl_out
);
   logic ovf_d, ext_d;

   always_comb begin
      ovf_d = ovf_evt ? 1'b1 : (flag_clr[0] ? 1'b0 : ovf_flag);
      if (updn)
         ext_d = ovf_evt ? ~ext_flag : (flag_clr[1] ? 1'b0 : ext_flag);
      else
         ext_d = ext_evt ? 1'b1 : (flag_clr[1] ? 1'b0 : ext_flag);
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         ovf_flag <= 1'b0;
         ext_flag <= 1'b0;
      end else begin
         ovf_flag <= ovf_d;
         ext_flag <= ext_d;
      end

   generate
      if (HAS_TOGGLE) begin : g_toggle
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n)                                 tgl_out <= 1'b0;
            else if (ovf_evt && out_en && !tick_ext_src) tgl_out <= ~tgl_out;

         // R7: toggle on internal-tick overflow
         a_r7_toggle: assert property (@(posedge clk) disable iff (!rst_n)
            (ovf_evt && out_en && !tick_ext_src) |=> tgl_out != $past(tgl_out));
      end else begin : g_no_toggle
         assign tgl_out = 1'b0;
      end
   endgenerate

   // R8: hardware set beats a clear
   a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_evt |=> ovf_flag);
   // R8: flag holds without event or clear
   a_r8_ovf_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!ovf_evt && !flag_clr[0]) |=> $stable(ovf_flag));
   // R5: wrap parity in up/down style
   a_r5_ext_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_evt && updn) |=> ext_flag != $past(ext_flag));
endmodule

// File: rtl/updn_reload_timer.sv
module updn_reload_timer
   import urt_pkg::*;
#(
   parameter int W           = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit HAS_TOGGLE  = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 run,
   input  logic                 tick,
   input  logic                 tick_ext_src,
   input  logic                 ctl_pin,
   input  logic                 cnt_we,
   input  logic [W-1:0]         cnt_wdata,
   input  logic                 rld_we,
   input  logic [W-1:0]         rld_wdata,
   input  logic                 cfg_we,
   input  logic [URT_CFG_W-1:0] cfg_wdata,
   input  logic [1:0]           flag_clr,
   output logic [W-1:0]         cnt_q,
   output logic [W-1:0]         rld_q,
   output logic [URT_CFG_W-1:0] cfg_q,
   output logic                 ovf_flag,
   output logic                 ext_flag,
   output logic                 tgl_out
);
   urt_cfg_t cfg_r;
   logic     pin_level, pin_fall, ovf_evt, ext_evt, updn;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)      cfg_r <= '0;
      else if (cfg_we) cfg_r <= urt_cfg_t'(cfg_wdata);

   assign cfg_q = cfg_r;

   urt_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .pin   (ctl_pin),
      .level (pin_level),
      .fall  (pin_fall)
   );

   urt_count_core #(.W(W)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .tick      (tick),
      .cfg       (cfg_r),
      .dir_level (pin_level),
      .fall      (pin_fall),
      .cnt_we    (cnt_we),
      .cnt_wdata (cnt_wdata),
      .rld_we    (rld_we),
      .rld_wdata (rld_wdata),
      .cnt_q     (cnt_q),
      .rld_q     (rld_q),
      .ovf_evt   (ovf_evt),
      .ext_evt   (ext_evt),
      .updn      (updn)
   );

   urt_flag_out #(.HAS_TOGGLE(HAS_TOGGLE)) u_flags (
      .clk          (clk),
      .rst_n        (rst_n),
      .ovf_evt      (ovf_evt),
      .ext_evt      (ext_evt),
      .updn         (updn),
      .out_en       (cfg_r.out_en),
      .tick_ext_src (tick_ext_src),
      .flag_clr     (flag_clr),
      .ovf_flag     (ovf_flag),
      .ext_flag     (ext_flag),
      .tgl_out      (tgl_out)
   );

   // R1: configuration reads back what was written
   a_r1_cfg_write: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> cfg_q == $past(cfg_wdata));
endmodule

// File: tb/updn_reload_timer_bench.sv
module updn_reload_timer_bench;
   localparam int SEL_CNT = 0, SEL_RLD = 1, SEL_OVF = 2, SEL_EXT = 3, SEL_TGL = 4;

   typedef struct {
      string       req;
      int          sel;
      logic [15:0] exp;
   } item_t;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        run = 1'b0, tick = 1'b0, tick_ext_src = 1'b0, ctl_pin = 1'b1;
   logic        cnt_we = 1'b0, rld_we = 1'b0, cfg_we = 1'b0;
   logic [15:0] cnt_wdata = '0, rld_wdata = '0;
   logic [3:0]  cfg_wdata = '0;
   logic [1:0]  flag_clr = '0;
   logic [15:0] cnt_q, rld_q;
   logic [3:0]  cfg_q;
   logic        ovf_flag, ext_flag, tgl_out;

   int    n_cmp = 0, n_bad = 0;
   bit    done = 1'b0;
   item_t sb_q[$];
   item_t it;
   logic [15:0] act;

   always #2 clk = ~clk;

   updn_reload_timer u_updn_reload_timer (
      .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .tick_ext_src(tick_ext_src),
      .ctl_pin(ctl_pin), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .rld_we(rld_we),
      .rld_wdata(rld_wdata), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .flag_clr(flag_clr),
      .cnt_q(cnt_q), .rld_q(rld_q), .cfg_q(cfg_q), .ovf_flag(ovf_flag),
      .ext_flag(ext_flag), .tgl_out(tgl_out)
   );

   // monitor: pops expectations and compares away from the rising edge
   always @(negedge clk) begin
      while (sb_q.size() > 0) begin
         it = sb_q.pop_front();
         case (it.sel)
            SEL_CNT: act = cnt_q;
            SEL_RLD: act = rld_q;
            SEL_OVF: act = {15'd0, ovf_flag};
            SEL_EXT: act = {15'd0, ext_flag};
            default: act = {15'd0, tgl_out};
         endcase
         n_cmp++;
         if (act !== it.exp) begin
            n_bad++;
            $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
         end
      end
   end

   task automatic chk(input string req, input int sel, input logic [15:0] exp);
      item_t e;
      e.req = req; e.sel = sel; e.exp = exp;
      sb_q.push_back(e);
   endtask

   task automatic cyc();
      @(posedge clk); #1;
      cnt_we = 1'b0; rld_we = 1'b0; cfg_we = 1'b0; flag_clr = 2'b00;
   endtask

   task automatic wcnt(input logic [15:0] v);
      cnt_we = 1'b1; cnt_wdata = v;
   endtask

   task automatic wcfg(input logic [3:0] v);
      cfg_we = 1'b1; cfg_wdata = v;
   endtask

   task automatic pin_to(input logic v);
      ctl_pin = v;
      repeat (3) cyc();
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      chk("R1", SEL_CNT, 16'h0000); chk("R1", SEL_RLD, 16'h0000);
      chk("R1", SEL_OVF, 16'h0); chk("R1", SEL_EXT, 16'h0); chk("R1", SEL_TGL, 16'h0);
      rst_n = 1'b1;
      cyc();

      // R2 up-count reload
      run = 1'b1;
      wcnt(16'hFFFD); rld_we = 1'b1; rld_wdata = 16'h1234;
      cyc(); chk("R9", SEL_CNT, 16'hFFFD); chk("R2", SEL_RLD, 16'h1234);
      tick = 1'b1;
      cyc(); chk("R2", SEL_CNT, 16'hFFFE);
      cyc(); chk("R2", SEL_CNT, 16'hFFFF); chk("R2", SEL_OVF, 16'h0);
      cyc(); chk("R2", SEL_CNT, 16'h1234); chk("R2", SEL_OVF, 16'h1);
      chk("R7", SEL_TGL, 16'h0); // output-enable clear
      // R10 hold
      run = 1'b0;
      cyc(); chk("R10", SEL_CNT, 16'h1234);
      run = 1'b1; tick = 1'b0;
      cyc(); chk("R10", SEL_CNT, 16'h1234);
      // R8 clear
      flag_clr = 2'b01;
      cyc(); chk("R8", SEL_OVF, 16'h0);
      // R9 write beats overflow
      wcnt(16'hFFFF); cyc();
      tick = 1'b1; wcnt(16'h0042);
      cyc(); chk("R9", SEL_CNT, 16'h0042); chk("R9", SEL_OVF, 16'h0);
      tick = 1'b0;

      // R7 toggle output
      wcfg(4'b1000); wcnt(16'hFFFF); cyc();
      tick = 1'b1;
      cyc(); chk("R7", SEL_TGL, 16'h1); chk("R2", SEL_CNT, 16'h1234);
      tick = 1'b0; tick_ext_src = 1'b1; wcnt(16'hFFFF); cyc();
      tick = 1'b1;
      cyc(); chk("R7", SEL_TGL, 16'h1);
      tick = 1'b0; tick_ext_src = 1'b0;
      // R8 set beats clear
      flag_clr = 2'b01; cyc(); chk("R8", SEL_OVF, 16'h0);
      wcnt(16'hFFFF); cyc();
      tick = 1'b1; flag_clr = 2'b01;
      cyc(); chk("R8", SEL_OVF, 16'h1); chk("R7", SEL_TGL, 16'h0);
      tick = 1'b0;

      // R3 pin-forced reload
      wcfg(4'b0010); wcnt(16'h0005); cyc();
      ctl_pin = 1'b0;
      cyc(); cyc(); chk("R3", SEL_CNT, 16'h0005);
      cyc(); chk("R3", SEL_CNT, 16'h1234); chk("R3", SEL_EXT, 16'h1);
      pin_to(1'b1);
      wcfg(4'b0000); flag_clr = 2'b10; wcnt(16'h0007); cyc();
      pin_to(1'b0); chk("R3", SEL_CNT, 16'h0007); chk("R3", SEL_EXT, 16'h0);
      pin_to(1'b1);

      // R4 / R5 up/down
      wcfg(4'b0110); flag_clr = 2'b11; rld_we = 1'b1; rld_wdata = 16'h0010; wcnt(16'h0012);
      cyc();
      pin_to(1'b0); chk("R5", SEL_CNT, 16'h0012); chk("R5", SEL_EXT, 16'h0);
      tick = 1'b1;
      cyc(); chk("R4", SEL_CNT, 16'h0011);
      cyc(); chk("R4", SEL_CNT, 16'h0010);
      cyc(); chk("R4", SEL_CNT, 16'hFFFF); chk("R4", SEL_OVF, 16'h1); chk("R5", SEL_EXT, 16'h1);
      cyc(); chk("R4", SEL_CNT, 16'hFFFE);
      tick = 1'b0;
      pin_to(1'b1);
      tick = 1'b1;
      cyc(); chk("R4", SEL_CNT, 16'hFFFF);
      cyc(); chk("R4", SEL_CNT, 16'h0010); chk("R5", SEL_EXT, 16'h0);
      tick = 1'b0;

      // R6 capture
      wcfg(4'b0011); flag_clr = 2'b11; wcnt(16'hFFFE); cyc();
      tick = 1'b1;
      cyc(); chk("R6", SEL_CNT, 16'hFFFF);
      cyc(); chk("R6", SEL_CNT, 16'h0000); chk("R6", SEL_OVF, 16'h1);
      cyc(); cyc(); chk("R6", SEL_CNT, 16'h0002);
      tick = 1'b0;
      pin_to(1'b0);
      chk("R6", SEL_RLD, 16'h0002); chk("R6", SEL_EXT, 16'h1); chk("R6", SEL_CNT, 16'h0002);
      pin_to(1'b1);

      cyc(); cyc();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule